// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block serialises one data word per frame onto a single output line that rests high. A frame is one low start bit, then the data bits with the least significant bit first, then a fixed number of high stop bits. A configuration bit selects a data field of eight or nine bits. When parity is on, the last bit of the data field carries a computed parity bit in place of the data bit that would sit there, so turning parity on does not make the frame longer. Each line bit lasts exactly one cycle of an external baud tick strobe.

Words enter through a valid/ready port into a one-word holding register. The ready output is the holding-register-empty flag gated by the enable. While ready is low, a word that is offered stays with the sender and is not consumed, so the sender must hold `tx_valid` and `tx_data` until it sees ready. The empty flag also drives an interrupt output, which its own enable input masks. The three configuration bits are captured only while the block is disabled. Each frame takes its settings when it leaves the holding register, so a frame already on the line is never changed. Clearing the enable stops new words and new frames. A frame already on the line still runs to its last stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `txe` is 1 and `irq` is 0 while `txe_irq_en` is 0.
- R2: A frame is one low start bit, then the data field least significant bit first, then STOP_BITS high bits. Each line bit lasts one baud tick. The data field is 8 bits when the stored word-length bit is 0 and 9 bits when it is 1.
- R3: With stored parity-enable at 1, the last bit of the data field (bit index 7 in 8-bit mode, index 8 in 9-bit mode) is the parity bit instead of the matching `tx_data` bit.
- R4: The parity bit covers the data bits sent before it in the same frame. Stored parity-select 0 makes the number of ones across those bits plus the parity bit even. Stored parity-select 1 makes it odd.
- R5: `cfg_we` updates the stored word-length, parity-enable and parity-select only on a clock edge where `enable` is 0. At any other edge the write is dropped, and later frames show the old settings.
- R6: A frame uses the settings stored when it left the holding register. Settings changed while the frame is on the line apply only from the next frame.
- R7: `txe` falls on the edge that accepts a word (`tx_valid` and `tx_ready` both 1). It rises on the baud tick that moves the word into the shifter.
- R8: `irq` equals `txe` AND `txe_irq_en` at all times.
- R9: A frame starts (line goes low) on the first baud tick after the holding register fills while the line is idle. A word already waiting is started on the tick that ends the previous frame's last stop bit, so no idle bit lies between the frames.
- R10: `tx_ready` is `txe` AND `enable`. A word offered while `tx_ready` is 0 is not taken: it neither replaces the waiting word nor makes an extra frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Transmitter enable; when low, config writes are accepted |
| baud_tick | input | 1 | One-cycle strobe marking each bit period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word9 | input | 1 | Word length: 0 = 8 data bits, 1 = 9 data bits |
| cfg_par_en | input | 1 | 1 = last data-field bit carries parity |
| cfg_par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| txe_irq_en | input | 1 | Interrupt mask for the empty flag |
| tx_valid | input | 1 | Data word offered |
| tx_data | input | DATA_MAX | Data word |
| tx_ready | output | 1 | Holding register can take a word |
| txe | output | 1 | Holding register empty |
| irq | output | 1 | Empty-flag interrupt |
| txd | output | 1 | Serial line, idle high |

## Verification
The bench sweeps every combination of word length, parity enable and parity select, with hundreds of data patterns in each. From the data it computes the bit sequence that should appear on the line and checks each frame against it. A design that leaves parity as an extra bit, puts it in the wrong slot, inverts its sense, or includes the wrong bits in it would corrupt the compared field or the stop bit. Directed cases attempt a configuration write while enabled, and a configuration change while a frame is on the line. A design that latched settings too late would send a frame of the wrong length or with the wrong parity. Timing cases measure the tick on which a frame starts and the idle gap between frames sent back to back; a design with an extra bit period or a lost word would show a different count. An offer made while the holding register is full must leave both the waiting word and the number of frames unchanged.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef struct packed {
    logic word9;
    logic par_en;
    logic par_odd;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_RESET = '{word9: 1'b0, par_en: 1'b0, par_odd: 1'b0};

endpackage

// File: rtl/uart_tx_cfg_reg.sv
module uart_tx_cfg_reg
  import uart_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    cfg_we,
  input  tx_cfg_t cfg_in,
  output tx_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_we && !enable) begin
      cfg_q <= cfg_in;
    end
  end

  // R5
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> $stable(cfg_q));

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                wr_valid,
  input  logic [DATA_MAX-1:0] wr_data,
  output logic                wr_ready,
  input  logic                take,
  output logic [DATA_MAX-1:0] hold_data,
  output logic                hold_full
);

  logic accept;

  assign wr_ready = !hold_full && enable;
  assign accept   = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  // R7
  txe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> hold_full);

  // R7
  txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_full) |-> $past(take));

  // R10
  take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_full);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_MAX  = 9,
  parameter int STOP_BITS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                baud_tick,
  input  logic                hold_full,
  input  logic [DATA_MAX-1:0] hold_data,
  input  tx_cfg_t             cfg,
  output logic                take,
  output logic                txd
);

  localparam int SH_W  = DATA_MAX + STOP_BITS;
  localparam int FRM_W = 1 + SH_W;
  localparam int CNT_W = $clog2(FRM_W + 1);

  logic [SH_W-1:0]     sreg;
  logic [CNT_W-1:0]    bits_left;
  logic [DATA_MAX-1:0] payload;
  logic [SH_W-1:0]     load_vec;
  logic [CNT_W-1:0]    load_len;
  logic                par_acc;
  int                  n_bits;

  always_comb begin
    n_bits  = cfg.word9 ? DATA_MAX : DATA_MAX - 1;
    par_acc = cfg.par_odd;
    payload = '1;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < n_bits) payload[i] = hold_data[i];
      if (i < n_bits - 1) par_acc = par_acc ^ hold_data[i];
    end
    for (int i = 0; i < DATA_MAX; i++) begin
      if (cfg.par_en && (i == n_bits - 1)) payload[i] = par_acc;
    end
    load_vec = {{STOP_BITS{1'b1}}, payload};
    load_len = CNT_W'(1 + STOP_BITS) +
               (cfg.word9 ? CNT_W'(DATA_MAX) : CNT_W'(DATA_MAX - 1));
  end

  assign take = baud_tick && enable && hold_full && (bits_left <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg      <= '1;
      bits_left <= '0;
      txd       <= 1'b1;
    end else if (baud_tick) begin
      if (take) begin
        sreg      <= load_vec;
        bits_left <= load_len;
        txd       <= 1'b0;
      end else if (bits_left > CNT_W'(1)) begin
        txd       <= sreg[0];
        sreg      <= {1'b1, sreg[SH_W-1:1]};
        bits_left <= bits_left - CNT_W'(1);
      end else begin
        bits_left <= '0;
        txd       <= 1'b1;
      end
    end
  end

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd);

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_left == '0) |-> txd);

  // R9
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && (bits_left == CNT_W'(1)) && hold_full && enable) |=> !txd);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_MAX  = 9,
  parameter int STOP_BITS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                baud_tick,
  input  logic                cfg_we,
  input  logic                cfg_word9,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                txe_irq_en,
  input  logic                tx_valid,
  input  logic [DATA_MAX-1:0] tx_data,
  output logic                tx_ready,
  output logic                txe,
  output logic                irq,
  output logic                txd
);

  tx_cfg_t             cfg_in;
  tx_cfg_t             cfg_q;
  logic                take;
  logic                hold_full;
  logic [DATA_MAX-1:0] hold_data;

  assign cfg_in = '{word9: cfg_word9, par_en: cfg_par_en, par_odd: cfg_par_odd};

  uart_tx_cfg_reg cfg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .cfg_we (cfg_we),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  uart_tx_hold #(.DATA_MAX(DATA_MAX)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .wr_valid  (tx_valid),
    .wr_data   (tx_data),
    .wr_ready  (tx_ready),
    .take      (take),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  uart_tx_shift #(.DATA_MAX(DATA_MAX), .STOP_BITS(STOP_BITS)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .baud_tick (baud_tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .cfg       (cfg_q),
    .take      (take),
    .txd       (txd)
  );

  assign txe = !hold_full;
  assign irq = txe && txe_irq_en;

  // R8
  irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && enable) |-> tx_ready);

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

  localparam int DATA_MAX  = 9;
  localparam int STOP_BITS = 1;
  localparam int LOG_N     = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_word9 = 1'b0;
  logic cfg_par_en = 1'b0;
  logic cfg_par_odd = 1'b0;
  logic txe_irq_en = 1'b0;
  logic tx_valid = 1'b0;
  logic [DATA_MAX-1:0] tx_data = '0;
  logic tx_ready, txe, irq, txd;
  logic baud_tick;
  logic [1:0] tick_cnt = '0;
  logic tick_seen = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int wr_cnt = 0;
  int frames_done = 0;
  int wr_ticks = 0;
  int rx_n = 8;
  logic [DATA_MAX-1:0] exp_log [LOG_N];
  logic [DATA_MAX-1:0] rx_log [LOG_N];
  int gap_log [LOG_N];
  int wait_log [LOG_N];

  logic rx_busy = 1'b0;
  int rx_idx = 0;
  int idle_run = 0;
  logic [DATA_MAX-1:0] rx_word = '0;
  logic rx_stop_ok = 1'b1;

  logic m_w9 = 1'b0, m_pe = 1'b0, m_po = 1'b0;

  always #2.5 clk = ~clk;

  assign baud_tick = (tick_cnt == 2'd3);

  uart_frame_tx #(.DATA_MAX(DATA_MAX), .STOP_BITS(STOP_BITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .baud_tick(baud_tick),
    .cfg_we(cfg_we), .cfg_word9(cfg_word9), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .txe_irq_en(txe_irq_en), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .txe(txe), .irq(irq), .txd(txd)
  );

  always @(posedge clk) begin
    tick_cnt  <= tick_cnt + 2'd1;
    tick_seen <= baud_tick;
    cycles    <= cycles + 1;
    if (tx_valid && tx_ready) wr_ticks <= 0;
    else if (baud_tick) wr_ticks <= wr_ticks + 1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Line monitor: samples txd once per bit period.
  always @(negedge clk) begin
    if (rst_n && tick_seen) begin
      if (!rx_busy) begin
        if (txd == 1'b0) begin
          rx_busy = 1'b1;
          rx_idx = 0;
          rx_word = '0;
          rx_stop_ok = 1'b1;
          gap_log[frames_done % LOG_N] = idle_run;
          wait_log[frames_done % LOG_N] = wr_ticks;
          idle_run = 0;
        end else begin
          idle_run++;
        end
      end else begin
        if (rx_idx < rx_n) rx_word[rx_idx] = txd;
        else if (txd != 1'b1) rx_stop_ok = 1'b0;
        rx_idx++;
        if (rx_idx == rx_n + STOP_BITS) begin
          rx_busy = 1'b0;
          check(rx_stop_ok, "R2 stop bit", int'(rx_stop_ok), 1);
          rx_log[frames_done % LOG_N] = rx_word;
          frames_done++;
        end
      end
    end
  end

  function automatic logic [DATA_MAX-1:0] expect_word(input logic [DATA_MAX-1:0] d,
      input logic w9, input logic pe, input logic po);
    int n;
    logic p;
    logic [DATA_MAX-1:0] r;
    n = w9 ? 9 : 8;
    r = '0;
    p = po;
    for (int i = 0; i < n; i++) r[i] = d[i];
    for (int i = 0; i < n - 1; i++) p = p ^ d[i];
    if (pe) r[n-1] = p;
    return r;
  endfunction

  task automatic set_cfg(input logic w9, input logic pe, input logic po);
    @(negedge clk);
    cfg_word9 = w9; cfg_par_en = pe; cfg_par_odd = po; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [DATA_MAX-1:0] d);
    @(negedge clk);
    while (!tx_ready || baud_tick) @(negedge clk);
    tx_valid = 1'b1;
    tx_data = d;
    exp_log[wr_cnt % LOG_N] = expect_word(d, m_w9, m_pe, m_po);
    wr_cnt++;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    while (frames_done != wr_cnt || rx_busy) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic compare_from(input int first, input string tag);
    for (int k = first; k < wr_cnt; k++)
      check(rx_log[k % LOG_N] == exp_log[k % LOG_N], tag,
            int'(rx_log[k % LOG_N]), int'(exp_log[k % LOG_N]));
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    check(txe == 1'b1, "R1 txe", int'(txe), 1);
    check(irq == 1'b0, "R1 irq", int'(irq), 0);

    // R2 R3 R4 sweep over every configuration
    for (int c = 0; c < 8; c++) begin
      enable = 1'b0;
      m_w9 = c[2]; m_pe = c[1]; m_po = c[0];
      rx_n = m_w9 ? 9 : 8;
      set_cfg(m_w9, m_pe, m_po);
      enable = 1'b1;
      first = wr_cnt;
      if (m_w9) for (int d = 0; d < 128; d++) send(DATA_MAX'((d * 37 + c * 11) % 512));
      else for (int d = 0; d < 256; d++) send(DATA_MAX'(d + 256 * (d % 2)));
      drain();
      compare_from(first, m_pe ? "R3 R4 parity frame" : "R2 data frame");
    end

    // R5 config write while enabled is dropped
    enable = 1'b0;
    m_w9 = 1'b0; m_pe = 1'b0; m_po = 1'b0; rx_n = 8;
    set_cfg(1'b0, 1'b0, 1'b0);
    enable = 1'b1;
    set_cfg(1'b1, 1'b1, 1'b1);
    first = wr_cnt;
    send(9'h1A5);
    send(9'h0FF);
    drain();
    compare_from(first, "R5 locked config");

    // R6 change during frame applies from the next frame
    first = wr_cnt;
    send(9'h0B3);
    while (!rx_busy) @(negedge clk);
    enable = 1'b0;
    set_cfg(1'b1, 1'b1, 1'b1);
    drain();
    compare_from(first, "R6 frame in flight");
    m_w9 = 1'b1; m_pe = 1'b1; m_po = 1'b1; rx_n = 9;
    enable = 1'b1;
    first = wr_cnt;
    send(9'h0B3);
    drain();
    compare_from(first, "R6 next frame");

    // R9 start tick and back-to-back gap; R7 txe; R10 back-pressure; R8 irq
    enable = 1'b0;
    m_w9 = 1'b0; m_pe = 1'b1; m_po = 1'b0; rx_n = 8;
    set_cfg(1'b0, 1'b1, 1'b0);
    enable = 1'b1;
    txe_irq_en = 1'b1;
    repeat (12) @(negedge clk);
    check(irq == 1'b1, "R8 irq with txe", int'(irq), 1);
    first = wr_cnt;
    send(9'h03C);
    check(txe == 1'b0, "R7 txe cleared on write", int'(txe), 0);
    check(irq == 1'b0, "R8 irq follows txe", int'(irq), 0);
    while (!rx_busy) @(negedge clk);
    check(wait_log[first % LOG_N] == 1, "R9 first tick start", wait_log[first % LOG_N], 1);
    check(txe == 1'b1, "R7 txe set at load", int'(txe), 1);
    send(9'h0C1);
    // holding register full now: offered word must be refused
    @(negedge clk);
    check(tx_ready == 1'b0, "R10 ready low when full", int'(tx_ready), 0);
    tx_valid = 1'b1; tx_data = 9'h155;
    repeat (3) @(negedge clk);
    tx_valid = 1'b0;
    txe_irq_en = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R8 irq masked", int'(irq), 0);
    drain();
    repeat (60) @(negedge clk);
    compare_from(first, "R10 waiting word kept");
    check(frames_done == wr_cnt, "R10 no extra frame", frames_done, wr_cnt);
    check(gap_log[(first + 1) % LOG_N] == 0, "R9 back-to-back gap",
          gap_log[(first + 1) % LOG_N], 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule